// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the scan timing for a parallel RGB panel. A per-pixel enable, a divided pixel clock, line and frame sync, a data-enable strobe and the active-area coordinates come out of it. A display pipeline fetches and drives pixel data against these signals. It also drives an AC-bias signal that toggles every few lines, an interrupt pulse after a programmed number of those toggles, and a one-cycle end-of-frame pulse.

Every timing value is a static configuration input. The active width is given in blocks of 16 pixels and the active height as lines minus one. Each porch and sync width is given as its length minus one. The generator copies the timing fields into a shadow set when a frame starts, so the inputs may change at any time. Raising the scan enable starts scanning at the next cycle. Dropping it lets the current frame run to its end, and after that the strobes stay inactive.

Top module: `lcd_timing_gen`

## Requirements
- R1: One pixel lasts D functional-clock cycles, where D is the divisor input, and any divisor below 2 acts as 2. `pixEn` pulses for one cycle at the start of each pixel. `pclkOut` is at its active level for the first floor(D/2) cycles of each pixel, starting in the same cycle as `pixEn`.
- R2: A line runs in this order: sync for hsw+1 pixels, back porch for hbp+1 pixels, (ppl+1)*16 active pixels, then front porch for hfp+1 pixels. hsync is active only during the sync pixels.
- R3: A frame runs in this order: vsw+1 sync lines, vbp+1 back-porch lines, lines+1 active lines, then vfp+1 front-porch lines. vsync is active only during the sync lines.
- R4: `deOut` is high only on pixels that are active both horizontally and vertically. Within each active run, `xPos` counts 0 to width-1. `yPos` is 0 on the first active line and rises by one on each later active line. deOut and active hsync never coincide.
- R5: When an inversion input is 1, the matching output is inverted: `cfgInvPclk` for pclkOut, `cfgInvHsync` for hsyncOut, `cfgInvVsync` for vsyncOut. The inversion also applies while the generator is idle.
- R6: When `cfgSyncSel`=1 and `cfgSyncFall`=1, hsync and vsync change floor(D/2) cycles after `pixEn`, which is the falling pixel-clock edge. In every other case they change in the same cycle as `pixEn`, and `cfgSyncFall` alone has no effect.
- R7: `eofPulse` is high for exactly one cycle after the last pixel of each frame. This is the cycle just before the next frame's first `pixEn`.
- R8: Timing fields that change during a frame take effect only from the next frame: width, height, porches, sync widths, divisor and AC-bias settings.
- R9: When `rasterEn` falls, the frame in progress completes with its full pixel count. After its `eofPulse`, no `pixEn` occurs, and deOut, hsync, vsync and pclk stay at their inactive levels until `rasterEn` rises again.
- R10: `acbOut` toggles after every cfgAcbPeriod+1 completed lines. It keeps its level while idle.
- R11: When cfgAcbTrans is N≠0, `acbIrq` pulses for one cycle on every Nth acbOut toggle. When N=0, no pulse occurs.
- R12: After reset, and before scanning starts, pixEn, deOut, eofPulse, acbIrq and acbOut are 0, xPos is 0, and the sync and pixel-clock outputs sit at their inactive levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rasterEn | input | 1 | Scan enable |
| cfgPplBlocks | input | 6 | Active width in 16-pixel blocks, minus one |
| cfgLinesM1 | input | 10 | Active lines minus one |
| cfgHSyncW | input | 6 | hsync width minus one (pixels) |
| cfgHBack | input | 8 | Horizontal back porch minus one |
| cfgHFront | input | 8 | Horizontal front porch minus one |
| cfgVSyncW | input | 6 | vsync width minus one (lines) |
| cfgVBack | input | 8 | Vertical back porch minus one |
| cfgVFront | input | 8 | Vertical front porch minus one |
| cfgPixDiv | input | 8 | Pixel clock divisor (values below 2 act as 2) |
| cfgInvPclk | input | 1 | Invert pixel clock output |
| cfgInvHsync | input | 1 | Invert hsync output |
| cfgInvVsync | input | 1 | Invert vsync output |
| cfgSyncSel | input | 1 | Enable sync-edge selection |
| cfgSyncFall | input | 1 | Sync changes on falling pixel-clock edge (needs cfgSyncSel) |
| cfgAcbPeriod | input | 8 | Lines between AC-bias toggles, minus one |
| cfgAcbTrans | input | 4 | AC-bias toggles per interrupt (0 = off) |
| pixEn | output | 1 | One-cycle pulse at the start of each pixel |
| pclkOut | output | 1 | Divided pixel clock |
| hsyncOut | output | 1 | Line sync |
| vsyncOut | output | 1 | Frame sync |
| deOut | output | 1 | Data enable |
| xPos | output | 10 | Active-area column |
| yPos | output | 10 | Active-area line |
| acbOut | output | 1 | AC-bias toggle |
| acbIrq | output | 1 | AC-bias transition-count pulse |
| eofPulse | output | 1 | End-of-frame pulse |

## Verification
The properties treat the polarity and sync-edge inputs as quasi-static. They may change at any time, but an edge-selection change in the middle of a line is allowed to disturb only the frame in which it happens. The stop property expects rasterEn to be sampled in the cycle before eofPulse. It is not expected to hold across a same-cycle restart. The directed stimulus follows these rules: configuration changes land away from frame ends, and every frame-level measurement is taken from a window that begins after the change has been absorbed by a frame boundary.

// File: rtl/lcd_timing_pkg.sv
package lcd_timing_pkg;
  parameter int PPL_W      = 6;
  parameter int LINE_W     = 10;
  parameter int PORCH_W    = 8;
  parameter int SYNC_W     = 6;
  parameter int DIV_W      = 8;
  parameter int ACB_PER_W  = 8;
  parameter int ACB_CNT_W  = 4;
  localparam int BLOCK_SHIFT = 4;
  localparam int X_W = PPL_W + BLOCK_SHIFT;

  typedef enum logic [1:0] {PH_SYNC, PH_BACK, PH_ACTIVE, PH_FRONT} phase_e;

  typedef struct packed {
    logic [PPL_W-1:0]     ppl;
    logic [LINE_W-1:0]    lines;
    logic [SYNC_W-1:0]    hsw;
    logic [PORCH_W-1:0]   hbp;
    logic [PORCH_W-1:0]   hfp;
    logic [SYNC_W-1:0]    vsw;
    logic [PORCH_W-1:0]   vbp;
    logic [PORCH_W-1:0]   vfp;
    logic [DIV_W-1:0]     div;
    logic [ACB_PER_W-1:0] acbPer;
    logic [ACB_CNT_W-1:0] acbCnt;
  } timing_cfg_t;

  typedef struct packed {
    logic                 running;
    logic                 pixStart;
    logic                 pixFall;
    logic                 pclkRaw;
    logic                 hsRaw;
    logic                 vsRaw;
    logic                 deRaw;
    logic                 lineEnd;
    logic                 frameEnd;
    logic [X_W-1:0]       x;
    logic [LINE_W-1:0]    y;
    logic [ACB_PER_W-1:0] acbPer;
    logic [ACB_CNT_W-1:0] acbCnt;
  } strobe_t;
endpackage

// File: rtl/lcd_phase_seq.sv
module lcd_phase_seq import lcd_timing_pkg::*; #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             restart,
  input  logic             step,
  input  logic [CNT_W-1:0] lenSync,
  input  logic [CNT_W-1:0] lenBack,
  input  logic [CNT_W-1:0] lenAct,
  input  logic [CNT_W-1:0] lenFront,
  output phase_e           phase,
  output logic [CNT_W-1:0] idx,
  output logic             wrap
);
  // Remaining units in the current phase, minus one.
  logic [CNT_W-1:0] left;

  assign wrap = (phase == PH_FRONT) && (left == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_SYNC;
      left  <= '0;
      idx   <= '0;
    end else if (restart) begin
      phase <= PH_SYNC;
      left  <= lenSync;
      idx   <= '0;
    end else if (step) begin
      if (left != '0) begin
        left <= left - 1'b1;
        if (phase == PH_ACTIVE) idx <= idx + 1'b1;
      end else begin
        unique case (phase)
          PH_SYNC:   begin phase <= PH_BACK;   left <= lenBack;  end
          PH_BACK:   begin phase <= PH_ACTIVE; left <= lenAct; idx <= '0; end
          PH_ACTIVE: begin phase <= PH_FRONT;  left <= lenFront; end
          default:   begin phase <= PH_SYNC;   left <= lenSync;  end
        endcase
      end
    end
  end
endmodule

// File: rtl/lcd_timing_ctrl.sv
module lcd_timing_ctrl import lcd_timing_pkg::*; (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rasterEn,
  input  timing_cfg_t cfgIn,
  output strobe_t     strb
);
  logic             running;
  timing_cfg_t      shadow;
  timing_cfg_t      lenSrc;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divEff;
  logic [DIV_W-1:0] divHalf;
  logic             tick, startNow, restart, frameEnd;
  logic             hWrap, vWrap;
  phase_e           hPhase, vPhase;
  logic [X_W-1:0]   hIdx;
  logic [LINE_W-1:0] vIdx;

  assign divEff   = (shadow.div < DIV_W'(2)) ? DIV_W'(2) : shadow.div;
  assign divHalf  = divEff >> 1;
  assign tick     = running && (divCnt == divEff - 1'b1);
  assign frameEnd = tick && hWrap && vWrap;
  assign startNow = !running && rasterEn;
  assign restart  = startNow || (frameEnd && rasterEn);
  // New lengths come straight from the inputs at a frame boundary.
  assign lenSrc   = restart ? cfgIn : shadow;

  lcd_phase_seq #(.CNT_W(X_W)) hSeq_i (
    .clk      (clk),
    .rstN     (rstN),
    .restart  (restart),
    .step     (tick),
    .lenSync  (X_W'(lenSrc.hsw)),
    .lenBack  (X_W'(lenSrc.hbp)),
    .lenAct   ({lenSrc.ppl, {BLOCK_SHIFT{1'b1}}}),
    .lenFront (X_W'(lenSrc.hfp)),
    .phase    (hPhase),
    .idx      (hIdx),
    .wrap     (hWrap)
  );

  lcd_phase_seq #(.CNT_W(LINE_W)) vSeq_i (
    .clk      (clk),
    .rstN     (rstN),
    .restart  (restart),
    .step     (tick && hWrap),
    .lenSync  (LINE_W'(lenSrc.vsw)),
    .lenBack  (LINE_W'(lenSrc.vbp)),
    .lenAct   (lenSrc.lines),
    .lenFront (LINE_W'(lenSrc.vfp)),
    .phase    (vPhase),
    .idx      (vIdx),
    .wrap     (vWrap)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      shadow  <= '0;
      divCnt  <= '0;
    end else if (startNow) begin
      running <= 1'b1;
      shadow  <= cfgIn;
      divCnt  <= '0;
    end else if (running) begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (frameEnd) begin
        if (rasterEn) shadow <= cfgIn;
        else          running <= 1'b0;
      end
    end
  end

  always_comb begin
    strb          = '0;
    strb.running  = running;
    strb.pixStart = running && (divCnt == '0);
    strb.pixFall  = running && (divCnt == divHalf);
    strb.pclkRaw  = running && (divCnt < divHalf);
    strb.hsRaw    = running && (hPhase == PH_SYNC);
    strb.vsRaw    = running && (vPhase == PH_SYNC);
    strb.deRaw    = running && (hPhase == PH_ACTIVE) && (vPhase == PH_ACTIVE);
    strb.lineEnd  = tick && hWrap;
    strb.frameEnd = frameEnd;
    strb.x        = hIdx;
    strb.y        = vIdx;
    strb.acbPer   = shadow.acbPer;
    strb.acbCnt   = shadow.acbCnt;
  end
endmodule

// File: rtl/lcd_timing_dp.sv
module lcd_timing_dp import lcd_timing_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              syncSel,
  input  logic              syncFall,
  input  logic              invPclk,
  input  logic              invHsync,
  input  logic              invVsync,
  output logic              pixEn,
  output logic              pclkOut,
  output logic              hsyncOut,
  output logic              vsyncOut,
  output logic              deOut,
  output logic [X_W-1:0]    xPos,
  output logic [LINE_W-1:0] yPos,
  output logic              acbOut,
  output logic              acbIrq,
  output logic              eofPulse
);
  logic pclkQ, hsQ, vsQ, syncLoad;
  logic [ACB_PER_W-1:0] lineCnt;
  logic [ACB_CNT_W-1:0] togCnt;

  assign syncLoad = (syncSel && syncFall) ? strb.pixFall : strb.pixStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixEn    <= 1'b0;
      pclkQ    <= 1'b0;
      hsQ      <= 1'b0;
      vsQ      <= 1'b0;
      deOut    <= 1'b0;
      xPos     <= '0;
      yPos     <= '0;
      eofPulse <= 1'b0;
    end else begin
      pixEn    <= strb.pixStart;
      pclkQ    <= strb.pclkRaw;
      eofPulse <= strb.frameEnd;
      if (!strb.running) begin
        hsQ   <= 1'b0;
        vsQ   <= 1'b0;
        deOut <= 1'b0;
      end else begin
        if (syncLoad) begin
          hsQ <= strb.hsRaw;
          vsQ <= strb.vsRaw;
        end
        if (strb.pixStart) begin
          deOut <= strb.deRaw;
          xPos  <= strb.x;
          yPos  <= strb.y;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineCnt <= '0;
      togCnt  <= '0;
      acbOut  <= 1'b0;
      acbIrq  <= 1'b0;
    end else begin
      acbIrq <= 1'b0;
      if (strb.lineEnd) begin
        if (lineCnt >= strb.acbPer) begin
          lineCnt <= '0;
          acbOut  <= ~acbOut;
          if (strb.acbCnt == '0) begin
            togCnt <= '0;
          end else if (togCnt >= strb.acbCnt - 1'b1) begin
            togCnt <= '0;
            acbIrq <= 1'b1;
          end else begin
            togCnt <= togCnt + 1'b1;
          end
        end else begin
          lineCnt <= lineCnt + 1'b1;
        end
      end
    end
  end

  assign pclkOut  = pclkQ ^ invPclk;
  assign hsyncOut = hsQ ^ invHsync;
  assign vsyncOut = vsQ ^ invVsync;
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen import lcd_timing_pkg::*; (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rasterEn,
  input  logic [PPL_W-1:0]     cfgPplBlocks,
  input  logic [LINE_W-1:0]    cfgLinesM1,
  input  logic [SYNC_W-1:0]    cfgHSyncW,
  input  logic [PORCH_W-1:0]   cfgHBack,
  input  logic [PORCH_W-1:0]   cfgHFront,
  input  logic [SYNC_W-1:0]    cfgVSyncW,
  input  logic [PORCH_W-1:0]   cfgVBack,
  input  logic [PORCH_W-1:0]   cfgVFront,
  input  logic [DIV_W-1:0]     cfgPixDiv,
  input  logic                 cfgInvPclk,
  input  logic                 cfgInvHsync,
  input  logic                 cfgInvVsync,
  input  logic                 cfgSyncSel,
  input  logic                 cfgSyncFall,
  input  logic [ACB_PER_W-1:0] cfgAcbPeriod,
  input  logic [ACB_CNT_W-1:0] cfgAcbTrans,
  output logic                 pixEn,
  output logic                 pclkOut,
  output logic                 hsyncOut,
  output logic                 vsyncOut,
  output logic                 deOut,
  output logic [X_W-1:0]       xPos,
  output logic [LINE_W-1:0]    yPos,
  output logic                 acbOut,
  output logic                 acbIrq,
  output logic                 eofPulse
);
  timing_cfg_t cfgBus;
  strobe_t     strb;

  always_comb begin
    cfgBus.ppl    = cfgPplBlocks;
    cfgBus.lines  = cfgLinesM1;
    cfgBus.hsw    = cfgHSyncW;
    cfgBus.hbp    = cfgHBack;
    cfgBus.hfp    = cfgHFront;
    cfgBus.vsw    = cfgVSyncW;
    cfgBus.vbp    = cfgVBack;
    cfgBus.vfp    = cfgVFront;
    cfgBus.div    = cfgPixDiv;
    cfgBus.acbPer = cfgAcbPeriod;
    cfgBus.acbCnt = cfgAcbTrans;
  end

  lcd_timing_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .rasterEn (rasterEn),
    .cfgIn    (cfgBus),
    .strb     (strb)
  );

  lcd_timing_dp dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .syncSel  (cfgSyncSel),
    .syncFall (cfgSyncFall),
    .invPclk  (cfgInvPclk),
    .invHsync (cfgInvHsync),
    .invVsync (cfgInvVsync),
    .pixEn    (pixEn),
    .pclkOut  (pclkOut),
    .hsyncOut (hsyncOut),
    .vsyncOut (vsyncOut),
    .deOut    (deOut),
    .xPos     (xPos),
    .yPos     (yPos),
    .acbOut   (acbOut),
    .acbIrq   (acbIrq),
    .eofPulse (eofPulse)
  );
endmodule

// File: rtl/lcd_timing_chk.sv
module lcd_timing_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rasterEn,
  input logic       cfgInvHsync,
  input logic       pixEn,
  input logic       hsyncOut,
  input logic       deOut,
  input logic [9:0] xPos,
  input logic       eofPulse,
  input logic       acbIrq
);
  // R1
  pix_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixEn |=> !pixEn);

  // R4
  de_sync_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    deOut |-> !(hsyncOut ^ cfgInvHsync));

  // R4
  x_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(deOut) |-> (xPos == 10'd0));

  // R7
  eof_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    eofPulse |=> !eofPulse);

  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eofPulse && !$past(rasterEn)) |=> !pixEn);

  // R11
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    acbIrq |=> !acbIrq);
endmodule

bind lcd_timing_gen lcd_timing_chk chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .rasterEn    (rasterEn),
  .cfgInvHsync (cfgInvHsync),
  .pixEn       (pixEn),
  .hsyncOut    (hsyncOut),
  .deOut       (deOut),
  .xPos        (xPos),
  .eofPulse    (eofPulse),
  .acbIrq      (acbIrq)
);

// File: tb/lcd_timing_gen_tb_top.sv
module lcd_timing_gen_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rasterEn = 1'b0;
  logic [5:0] cfgPplBlocks = 6'd0;
  logic [9:0] cfgLinesM1 = 10'd3;
  logic [5:0] cfgHSyncW = 6'd1;
  logic [7:0] cfgHBack = 8'd2;
  logic [7:0] cfgHFront = 8'd1;
  logic [5:0] cfgVSyncW = 6'd0;
  logic [7:0] cfgVBack = 8'd1;
  logic [7:0] cfgVFront = 8'd0;
  logic [7:0] cfgPixDiv = 8'd4;
  logic cfgInvPclk = 1'b0, cfgInvHsync = 1'b0, cfgInvVsync = 1'b0;
  logic cfgSyncSel = 1'b0, cfgSyncFall = 1'b0;
  logic [7:0] cfgAcbPeriod = 8'd0;
  logic [3:0] cfgAcbTrans = 4'd0;
  logic pixEn, pclkOut, hsyncOut, vsyncOut, deOut, acbOut, acbIrq, eofPulse;
  logic [9:0] xPos, yPos;

  always #5 clk = ~clk;

  lcd_timing_gen dut_i (
    .clk(clk), .rstN(rstN), .rasterEn(rasterEn),
    .cfgPplBlocks(cfgPplBlocks), .cfgLinesM1(cfgLinesM1),
    .cfgHSyncW(cfgHSyncW), .cfgHBack(cfgHBack), .cfgHFront(cfgHFront),
    .cfgVSyncW(cfgVSyncW), .cfgVBack(cfgVBack), .cfgVFront(cfgVFront),
    .cfgPixDiv(cfgPixDiv), .cfgInvPclk(cfgInvPclk), .cfgInvHsync(cfgInvHsync),
    .cfgInvVsync(cfgInvVsync), .cfgSyncSel(cfgSyncSel), .cfgSyncFall(cfgSyncFall),
    .cfgAcbPeriod(cfgAcbPeriod), .cfgAcbTrans(cfgAcbTrans),
    .pixEn(pixEn), .pclkOut(pclkOut), .hsyncOut(hsyncOut), .vsyncOut(vsyncOut),
    .deOut(deOut), .xPos(xPos), .yPos(yPos), .acbOut(acbOut), .acbIrq(acbIrq),
    .eofPulse(eofPulse)
  );

  int checks = 0, errors = 0, cycTotal = 0;
  bit done = 1'b0;

  // Monitor state
  int frames = 0, fPix = 0, fDe = 0, fHs = 0, fVs = 0, fCyc = 0;
  int lastPix, lastDe, lastHs, lastVs, lastCyc;
  int sinceP = 0, lastPeriod = 0, pclkHi = 0, lastPclkHi = 0, hsDelay = -1;
  int lastX = 0, lastY = 0, runLen = 0, lastRunLen = 0, xyErr = 0;
  bit prevDe = 0, runSeen = 0, prevHs = 0, prevAcb = 0;
  int acbPix = 0, lastAcbGap = 0, togSinceIrq = 0, lastIrqTog = 0, irqCount = 0;

  wire hsAct = hsyncOut ^ cfgInvHsync;
  wire vsAct = vsyncOut ^ cfgInvVsync;
  wire pcAct = pclkOut ^ cfgInvPclk;

  always @(negedge clk) if (rstN) begin
    fCyc++;
    if (hsAct && !prevHs) hsDelay = pixEn ? 0 : sinceP + 1;
    prevHs = hsAct;
    if (pixEn) begin
      lastPeriod = sinceP + 1; sinceP = 0;
      lastPclkHi = pclkHi; pclkHi = pcAct ? 1 : 0;
      fPix++; acbPix++;
      if (hsAct) fHs++;
      if (vsAct) fVs++;
      if (deOut) begin
        fDe++;
        if (prevDe) begin
          if (xPos != lastX + 1 || yPos != lastY) xyErr++;
          runLen++;
        end else begin
          if (xPos != 0) xyErr++;
          if (yPos != (runSeen ? lastY + 1 : 0)) xyErr++;
          runSeen = 1; runLen = 1;
        end
        lastX = xPos; lastY = yPos;
      end else if (prevDe) lastRunLen = runLen;
      prevDe = deOut;
    end else begin
      sinceP++;
      if (pcAct) pclkHi++;
    end
    if (acbOut != prevAcb) begin lastAcbGap = acbPix; acbPix = 0; togSinceIrq++; end
    prevAcb = acbOut;
    if (acbIrq) begin irqCount++; lastIrqTog = togSinceIrq; togSinceIrq = 0; end
    if (eofPulse) begin
      lastPix = fPix; lastDe = fDe; lastHs = fHs; lastVs = fVs; lastCyc = fCyc;
      fPix = 0; fDe = 0; fHs = 0; fVs = 0; fCyc = 0; runSeen = 0;
      frames++;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitFrames(int n);
    int target = frames + n;
    int t = 0;
    while (frames < target && t < 30000) begin @(posedge clk); t++; end
    if (frames < target) chk("frame timeout", frames, target);
  endtask

  // Expected frame figures from the configuration inputs.
  function automatic int hTot();
    return (cfgHSyncW + 1) + (cfgHBack + 1) + (cfgPplBlocks + 1) * 16 + (cfgHFront + 1);
  endfunction
  function automatic int vTot();
    return (cfgVSyncW + 1) + (cfgVBack + 1) + (cfgLinesM1 + 1) + (cfgVFront + 1);
  endfunction
  function automatic int divE();
    return (cfgPixDiv < 2) ? 2 : int'(cfgPixDiv);
  endfunction

  task automatic checkFrame(string tag);
    chk({tag, " R2 R3 pixels per frame"}, lastPix, hTot() * vTot());
    chk({tag, " R4 de pixels"}, lastDe, (cfgPplBlocks + 1) * 16 * (cfgLinesM1 + 1));
    chk({tag, " R2 hsync pixels"}, lastHs, (cfgHSyncW + 1) * vTot());
    chk({tag, " R3 vsync pixels"}, lastVs, (cfgVSyncW + 1) * hTot());
    chk({tag, " R1 pixel period"}, lastPeriod, divE());
    chk({tag, " R1 pclk active cycles"}, lastPclkHi, divE() / 2);
    chk({tag, " R4 run length"}, lastRunLen, (cfgPplBlocks + 1) * 16);
    chk({tag, " R4 x/y sequence errors"}, xyErr, 0);
  endtask

  task automatic t_reset();
    chk("R12 pixEn", pixEn, 0);
    chk("R12 deOut", deOut, 0);
    chk("R12 hsync", hsyncOut, 0);
    chk("R12 vsync", vsyncOut, 0);
    chk("R12 pclk", pclkOut, 0);
    chk("R12 eof", eofPulse, 0);
    chk("R12 acb", acbOut, 0);
    chk("R12 acbIrq", acbIrq, 0);
    chk("R12 xPos", xPos, 0);
  endtask

  task automatic t_basic();
    rasterEn = 1'b1;
    waitFrames(2);
    checkFrame("basic");
    chk("basic R7 frame cycles", lastCyc, hTot() * vTot() * divE());
    chk("basic R6 rising sync delay", hsDelay, 0);
    chk("basic R11 no irq with N=0", irqCount, 0);
  endtask

  task automatic t_shadow();
    int oldPix;
    oldPix = hTot() * vTot();
    waitFrames(1);
    repeat (100) @(posedge clk);
    cfgPplBlocks = 6'd1; cfgPixDiv = 8'd1;
    waitFrames(1);
    chk("R8 frame in progress keeps old size", lastPix, oldPix);
    waitFrames(1);
    checkFrame("shadow R8 new");
  endtask

  task automatic t_polarity();
    cfgInvPclk = 1'b1; cfgInvHsync = 1'b1; cfgInvVsync = 1'b1;
    waitFrames(2);
    checkFrame("R5 inverted");
  endtask

  task automatic t_syncEdge();
    cfgPixDiv = 8'd6; cfgSyncSel = 1'b1; cfgSyncFall = 1'b1;
    waitFrames(2);
    chk("R6 falling-edge sync delay", hsDelay, 3);
    checkFrame("R6 falling");
    cfgSyncSel = 1'b0;
    waitFrames(2);
    chk("R6 edge bit ignored without select", hsDelay, 0);
  endtask

  task automatic t_acb();
    int snap;
    cfgAcbPeriod = 8'd2; cfgAcbTrans = 4'd3;
    waitFrames(5);
    chk("R10 pixels between toggles", lastAcbGap, 3 * hTot());
    chk("R11 toggles per irq", lastIrqTog, 3);
    cfgAcbTrans = 4'd0;
    waitFrames(2);
    snap = irqCount;
    waitFrames(2);
    chk("R11 no irq when count is zero", irqCount, snap);
  endtask

  task automatic t_stop();
    int exp;
    exp = hTot() * vTot();
    waitFrames(1);
    repeat (50) @(posedge clk);
    rasterEn = 1'b0;
    waitFrames(1);
    chk("R9 stopping frame completes", lastPix, exp);
    repeat (60) @(posedge clk);
    @(negedge clk);
    chk("R9 no pixels after stop", fPix, 0);
    chk("R9 de idle", deOut, 0);
    chk("R9 R5 hsync idle inverted", hsyncOut, 1);
    chk("R9 R5 vsync idle inverted", vsyncOut, 1);
    chk("R9 R5 pclk idle inverted", pclkOut, 1);
    rasterEn = 1'b1;
    waitFrames(2);
    chk("R9 restart frame size", lastPix, exp);
  endtask

  always @(posedge clk) begin
    cycTotal++;
    if (cycTotal > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycTotal);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_basic();
    t_shadow();
    t_polarity();
    t_syncEdge();
    t_acb();
    t_stop();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule